// File: doc/BRIEF.md
# ADC Host Conversion Sequencer

This block is the host-side controller for a serial 12-bit sampling converter. It drives the conversion-control line (CNV) and the serial clock. It shifts a configuration word out on SDI and collects the result word from SDO. One start request runs one full cycle: acquisition, conversion start, data exchange and conversion wait. The cycle ends back in an idle state with CNV high.

The block offers three read timings. In the read-after timing, the whole exchange takes place while CNV is low for acquisition. In the read-during timing, a short CNV pulse starts the conversion and the exchange runs while CNV is held low during the conversion. In the split timing, the exchange begins in acquisition and pauses at a bit boundary while CNV pulses high. It then resumes with the bits that remain.

Every interval is a parameter counted in system-clock cycles: acquisition length, conversion length, pulse width, data window and the SCLK half period. The captured word is the one the converter returns from its previous conversion. The configuration sent takes effect two conversions later. The block only schedules the pins and does not interpret either word.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, CNV is high, SCLK is low, busy is low and result-valid is low.
- R2: A start request is taken only while idle. Busy rises in the next cycle and stays high until the conversion time has run out. A start request seen while busy has no effect.
- R3: The mode code is sampled with the start request: 0 selects read-after, 1 selects read-during, 2 selects split, and 3 acts as read-after.
- R4: In read-after mode, CNV is low once per run. All 12 bits are exchanged in that low phase, which lasts at least ACQ_CYC cycles and until the last bit is done. CNV then rises.
- R5: In read-during mode, CNV is low for exactly ACQ_CYC cycles with no SCLK edge. It is then high for exactly PULSE_CYC cycles, and then low while all 12 bits are exchanged.
- R6: In split mode, bits are exchanged from the first acquisition cycle. Once ACQ_CYC cycles have passed, the exchange stops at the next bit boundary. CNV then goes high for exactly PULSE_CYC cycles, and the remaining bits follow in the second low phase, 12 in total.
- R7: In read-during and split modes, CNV returns high fewer than WIN_CYC cycles after the conversion start (the CNV rising edge that ends acquisition).
- R8: From the conversion start, at least CONV_CYC cycles pass before busy drops. No new acquisition can begin before that.
- R9: SCLK is low whenever CNV is high. Each SCLK high phase lasts exactly SCLK_DIV cycles.
- R10: The configuration word leaves on SDI most significant bit first. SDI is stable across each SCLK rising edge and changes only together with a falling edge.
- R11: SDO is sampled at the end of each SCLK high phase, most significant bit first. The 12 samples form result_o.
- R12: Result-valid is a single-cycle pulse, once per run, right after the twelfth sample. result_o then holds its value until the next word completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion cycle |
| mode_i | input | 2 | Read timing code, sampled with the start |
| cfg_i | input | W | Configuration word to send, sampled with the start |
| result_o | output | W | Last captured result word |
| result_vld_o | output | 1 | One-cycle pulse when result_o is updated |
| busy_o | output | 1 | High from the accepted start until the return to idle |
| cnv_o | output | 1 | Conversion-control line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Serial data to the converter |
| sdo_i | input | 1 | Serial data from the converter |

## Verification
The assertions assume the parameters leave room for the pulse plus the resumed or full transfer inside the data window. The window check can only hold if PULSE_CYC plus twelve bit periods fits under WIN_CYC. The bench picks values that do. The checks also assume the converter changes SDO only after an SCLK falling edge, so the sample taken at the end of each high phase is stable. The bench's converter model advances its output word only on falling edges. It alters mode and configuration inputs only after they have been sampled, and it issues a second start only while busy is high.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    RD_AFTER  = 2'd0,
    RD_DURING = 2'd1,
    RD_SPAN   = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ACQ   = 3'd1,
    S_PULSE = 3'd2,
    S_XFER  = 3'd3,
    S_CONV  = 3'd4
  } seq_state_e;

  // Code 3 is not a mode of its own and falls back to read-after.
  function automatic rd_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd1:    return RD_DURING;
      2'd2:    return RD_SPAN;
      default: return RD_AFTER;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // System-clock cycles taken by one serial bit.
  function automatic int unsigned bit_cycles(input int unsigned half_period);
    return 2 * half_period;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned MAX      = 15,
  parameter bit          RST_FULL = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  output logic [$clog2(MAX+1)-1:0]     cnt_o
);
  localparam int CW = $clog2(MAX + 1);
  localparam logic [CW-1:0] TOP = CW'(MAX);

  logic [CW-1:0] rst_val;

  generate
    if (RST_FULL) begin : g_full
      assign rst_val = TOP;
    end else begin : g_zero
      assign rst_val = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_o <= rst_val;
    else if (clr_i)      cnt_o <= '0;
    else if (cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
  parameter int unsigned W   = 12,
  parameter int unsigned DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] cfg_i,
  input  logic         run_i,
  input  logic         sdo_i,
  output logic         sclk_o,
  output logic         sdi_o,
  output logic         bnd_o,
  output logic         done_o,
  output logic [W-1:0] res_o,
  output logic         res_vld_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(W + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
  localparam logic [BW-1:0] BITS_ALL = BW'(W);

  logic [PW-1:0] ph_q;
  logic [BW-1:0] bits_q;
  logic [W-1:0]  tx_q, rx_q;
  logic          step_w, fall_w, last_w;

  assign done_o = (bits_q == BITS_ALL);
  assign bnd_o  = !sclk_o && (ph_q == '0);
  assign step_w = run_i && !done_o && (ph_q == PH_LAST);
  assign fall_w = step_w && sclk_o;
  assign last_w = fall_w && (bits_q == BW'(W - 1));
  assign sdi_o  = tx_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= '0;
      sclk_o    <= 1'b0;
      bits_q    <= BITS_ALL;
      tx_q      <= '0;
      rx_q      <= '0;
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= last_w;
      if (load_i) begin
        ph_q   <= '0;
        sclk_o <= 1'b0;
        bits_q <= '0;
        tx_q   <= cfg_i;
      end else if (run_i && !done_o) begin
        if (step_w) begin
          ph_q   <= '0;
          sclk_o <= !sclk_o;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
        if (fall_w) begin
          tx_q   <= {tx_q[W-2:0], 1'b0};
          rx_q   <= {rx_q[W-2:0], sdo_i};
          bits_q <= bits_q + 1'b1;
        end
      end
      if (last_w) res_o <= {rx_q[W-2:0], sdo_i};
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned W         = 12,
  parameter int unsigned SCLK_DIV  = 2,
  parameter int unsigned ACQ_CYC   = 100,
  parameter int unsigned CONV_CYC  = 900,
  parameter int unsigned WIN_CYC   = 120,
  parameter int unsigned PULSE_CYC = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] cfg_i,
  output logic [W-1:0] result_o,
  output logic         result_vld_o,
  output logic         busy_o,
  output logic         cnv_o,
  output logic         sclk_o,
  output logic         sdi_o,
  input  logic         sdo_i
);
  localparam int unsigned PH_MAX = max2(ACQ_CYC, PULSE_CYC);
  localparam int PH_W = $clog2(PH_MAX + 1);
  localparam int CV_W = $clog2(CONV_CYC + 1);

  seq_state_e state_q, state_n;
  rd_mode_e   mode_q;
  logic [PH_W-1:0] ph_cnt;
  logic [CV_W-1:0] conv_cnt_q;

  // Named internal events, also observed by the bound checker.
  logic start_acc_w, acq_ok_w, pulse_ok_w, conv_ok_w;
  logic bit_bnd_w, bits_done_w, run_w, pause_w;
  logic conv_start_w, xfer_w, rac_w, ph_clr_w;

  assign start_acc_w  = (state_q == S_IDLE) && start_i;
  assign acq_ok_w     = (ph_cnt >= PH_W'(ACQ_CYC - 1));
  assign pulse_ok_w   = (ph_cnt >= PH_W'(PULSE_CYC - 1));
  assign conv_ok_w    = (conv_cnt_q >= CV_W'(CONV_CYC));
  assign rac_w        = (mode_q == RD_AFTER);
  assign xfer_w       = (state_q == S_XFER);
  assign ph_clr_w     = (state_n != state_q);
  assign conv_start_w = (state_q == S_ACQ) && (state_n != S_ACQ);
  assign pause_w      = (mode_q == RD_SPAN) && acq_ok_w && bit_bnd_w;
  assign run_w        = ((state_q == S_ACQ) && (mode_q != RD_DURING) && !pause_w) || xfer_w;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_n = S_ACQ;
      S_ACQ: begin
        unique case (mode_q)
          RD_DURING: if (acq_ok_w) state_n = S_PULSE;
          RD_SPAN:   if (acq_ok_w && (bits_done_w || bit_bnd_w)) state_n = S_PULSE;
          default:   if (acq_ok_w && bits_done_w) state_n = S_CONV;
        endcase
      end
      S_PULSE: if (pulse_ok_w) state_n = bits_done_w ? S_CONV : S_XFER;
      S_XFER:  if (bits_done_w) state_n = S_CONV;
      S_CONV:  if (conv_ok_w) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= RD_AFTER;
    end else begin
      state_q <= state_n;
      if (start_acc_w) mode_q <= decode_mode(mode_i);
    end
  end

  assign cnv_o  = !((state_q == S_ACQ) || (state_q == S_XFER));
  assign busy_o = (state_q != S_IDLE);

  adc_seq_timer #(.MAX(PH_MAX), .RST_FULL(1'b0)) i_ph_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (ph_clr_w),
    .cnt_o (ph_cnt)
  );

  adc_seq_timer #(.MAX(CONV_CYC), .RST_FULL(1'b1)) i_conv_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (conv_start_w),
    .cnt_o (conv_cnt_q)
  );

  adc_seq_shift #(.W(W), .DIV(SCLK_DIV)) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (start_acc_w),
    .cfg_i     (cfg_i),
    .run_i     (run_w),
    .sdo_i     (sdo_i),
    .sclk_o    (sclk_o),
    .sdi_o     (sdi_o),
    .bnd_o     (bit_bnd_w),
    .done_o    (bits_done_w),
    .res_o     (result_o),
    .res_vld_o (result_vld_o)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int unsigned CV_W     = 10,
  parameter int unsigned CONV_CYC = 900,
  parameter int unsigned WIN_CYC  = 120
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            cnv_o,
  input logic            sclk_o,
  input logic            result_vld_o,
  input logic            conv_start_w,
  input logic            xfer_w,
  input logic            rac_w,
  input logic            bits_done_w,
  input logic [CV_W-1:0] conv_cnt_q
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cnv_o && !sclk_o));

  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  a_r4_rac_bits_before_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start_w && rac_w) |-> bits_done_w);

  a_r7_xfer_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_w |-> (32'(conv_cnt_q) < WIN_CYC));

  a_r8_conv_time_met: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (32'(conv_cnt_q) >= CONV_CYC));

  a_r9_sclk_low_cnv_high: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> !sclk_o);

  a_r12_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |=> !result_vld_o);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .CV_W     (CV_W),
  .CONV_CYC (CONV_CYC),
  .WIN_CYC  (WIN_CYC)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .cnv_o        (cnv_o),
  .sclk_o       (sclk_o),
  .result_vld_o (result_vld_o),
  .conv_start_w (conv_start_w),
  .xfer_w       (xfer_w),
  .rac_w        (rac_w),
  .bits_done_w  (bits_done_w),
  .conv_cnt_q   (conv_cnt_q)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int W    = 12;
  localparam int DIV  = 2;
  localparam int ACQ  = 30;
  localparam int CONV = 200;
  localparam int WIN  = 100;
  localparam int PUL  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [W-1:0] cfg_i = '0;
  logic [W-1:0] result_o;
  logic result_vld_o, busy_o, cnv_o, sclk_o, sdi_o, sdo_i;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl #(
    .W(W), .SCLK_DIV(DIV), .ACQ_CYC(ACQ), .CONV_CYC(CONV),
    .WIN_CYC(WIN), .PULSE_CYC(PUL)
  ) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .cfg_i(cfg_i), .result_o(result_o), .result_vld_o(result_vld_o),
    .busy_o(busy_o), .cnv_o(cnv_o), .sclk_o(sclk_o), .sdi_o(sdi_o),
    .sdo_i(sdo_i)
  );

  // Converter model: word advances on SCLK falls, SDI taken on SCLK rises.
  logic [W-1:0] dev_word = '0;
  logic [W-1:0] dev_rx = '0;
  int fall_total = 0;
  int base = 0;
  always @(negedge sclk_o) fall_total++;
  always @(posedge sclk_o) dev_rx <= {dev_rx[W-2:0], sdi_o};
  assign sdo_i = (cnv_o || (fall_total - base) >= W) ? 1'b0
                 : dev_word[W-1-(fall_total - base)];

  // Pin monitor, sampled between clock edges.
  int lo_len[4], hi_len[4], rises[4];
  int seg, vld_cnt, sclk_bad, bad_hi, hi_run;
  logic [W-1:0] vld_res;
  bit mon_on = 1'b0;
  logic prev_cnv = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (!cnv_o) begin
        if (prev_cnv) seg++;
        if (seg < 4) lo_len[seg]++;
      end else if (busy_o && seg < 4) hi_len[seg]++;
      if (sclk_o && !prev_sclk && seg < 4) rises[seg]++;
      if (cnv_o && sclk_o) sclk_bad++;
      if (sclk_o) hi_run++;
      else begin
        if (prev_sclk && hi_run != DIV) bad_hi++;
        hi_run = 0;
      end
      if (result_vld_o) begin vld_cnt++; vld_res = result_o; end
    end
    prev_cnv = cnv_o;
    prev_sclk = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [1:0] m, input logic [W-1:0] c,
                         input logic [W-1:0] w, input bit poke);
    dev_word = w;
    base = fall_total;
    for (int i = 0; i < 4; i++) begin lo_len[i] = 0; hi_len[i] = 0; rises[i] = 0; end
    seg = 0; vld_cnt = 0; sclk_bad = 0; bad_hi = 0; hi_run = 0;
    mon_on = 1'b1;
    @(negedge clk);
    mode_i = m; cfg_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; cfg_i = ~c; mode_i = ~m;
    chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1; cfg_i = '0; mode_i = 2'd0;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    mon_on = 1'b0;
  endtask

  task automatic chk_common(input string tag, input logic [W-1:0] c, input logic [W-1:0] w);
    chk(vld_cnt == 1, "R12", {tag, " valid pulses"}, vld_cnt, 1);
    chk(vld_res == w, "R11", {tag, " captured word"}, int'(vld_res), int'(w));
    chk(result_o == w, "R12", {tag, " result held"}, int'(result_o), int'(w));
    chk(dev_rx == c, "R10", {tag, " config seen by converter"}, int'(dev_rx), int'(c));
    chk(sclk_bad == 0, "R9", {tag, " SCLK high with CNV high"}, sclk_bad, 0);
    chk(bad_hi == 0, "R9", {tag, " SCLK high phase length"}, bad_hi, 0);
  endtask

  task automatic test_reset();
    chk(cnv_o == 1'b1, "R1", "CNV at reset", cnv_o, 1);
    chk(sclk_o == 1'b0, "R1", "SCLK at reset", sclk_o, 0);
    chk(busy_o == 1'b0, "R1", "busy at reset", busy_o, 0);
    chk(result_vld_o == 1'b0, "R1", "valid at reset", result_vld_o, 0);
  endtask

  task automatic test_after();
    run_txn(2'd0, 12'hA5C, 12'h3C9, 1'b0);
    chk(seg == 1, "R4", "low phases", seg, 1);
    chk(rises[1] == W, "R4", "bits in acquisition", rises[1], W);
    chk(lo_len[1] >= ACQ, "R4", "acquisition length", lo_len[1], ACQ);
    chk(lo_len[1] >= W * 2 * DIV, "R4", "low until transfer end", lo_len[1], W * 2 * DIV);
    chk(hi_len[1] >= CONV, "R8", "conversion hold", hi_len[1], CONV);
    chk(cnv_o == 1'b1 && sclk_o == 1'b0, "R1", "idle pins after run", cnv_o, 1);
    chk_common("read-after", 12'hA5C, 12'h3C9);
  endtask

  task automatic test_during();
    run_txn(2'd1, 12'h5E1, 12'hC36, 1'b0);
    chk(seg == 2, "R5", "low phases", seg, 2);
    chk(lo_len[1] == ACQ, "R5", "acquisition length", lo_len[1], ACQ);
    chk(rises[1] == 0, "R5", "SCLK in acquisition", rises[1], 0);
    chk(hi_len[1] == PUL, "R5", "pulse width", hi_len[1], PUL);
    chk(rises[2] == W, "R5", "bits in conversion", rises[2], W);
    chk(hi_len[1] + lo_len[2] < WIN, "R7", "window", hi_len[1] + lo_len[2], WIN);
    chk(hi_len[1] + lo_len[2] + hi_len[2] >= CONV, "R8", "conversion time",
        hi_len[1] + lo_len[2] + hi_len[2], CONV);
    chk_common("read-during", 12'h5E1, 12'hC36);
  endtask

  task automatic test_split();
    int bc = 2 * DIV;
    int pre = (ACQ - 1 + bc - 1) / bc;
    run_txn(2'd2, 12'h90F, 12'h6A5, 1'b0);
    chk(seg == 2, "R6", "low phases", seg, 2);
    chk(rises[1] == pre, "R6", "bits before pause", rises[1], pre);
    chk(rises[1] + rises[2] == W, "R6", "total bits", rises[1] + rises[2], W);
    chk(lo_len[1] >= ACQ, "R6", "acquisition length", lo_len[1], ACQ);
    chk(hi_len[1] == PUL, "R6", "pulse width", hi_len[1], PUL);
    chk(hi_len[1] + lo_len[2] < WIN, "R7", "window", hi_len[1] + lo_len[2], WIN);
    chk(hi_len[1] + lo_len[2] + hi_len[2] >= CONV, "R8", "conversion time",
        hi_len[1] + lo_len[2] + hi_len[2], CONV);
    chk_common("split", 12'h90F, 12'h6A5);
  endtask

  task automatic test_code3();
    run_txn(2'd3, 12'h0F3, 12'hB2D, 1'b0);
    chk(seg == 1, "R3", "code 3 low phases", seg, 1);
    chk(rises[1] == W, "R3", "code 3 bits in acquisition", rises[1], W);
    chk_common("code3", 12'h0F3, 12'hB2D);
  endtask

  task automatic test_busy_start();
    run_txn(2'd1, 12'h7C2, 12'h4E8, 1'b1);
    chk(seg == 2, "R2", "low phases with extra start", seg, 2);
    chk(vld_cnt == 1, "R2", "one word with extra start", vld_cnt, 1);
    chk(dev_rx == 12'h7C2, "R2", "config kept with extra start", int'(dev_rx), 'h7C2);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R2", "no run from extra start", busy_o, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_after();
    test_after();
    test_during();
    test_split();
    test_code3();
    test_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=hung expected=idle");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule